// File: doc/BRIEF.md
# Dual-Register Sine Synthesizer

This block is a direct digital synthesis core that turns a numeric tuning word into a stream of sampled sine values. It holds two frequency tuning words and two phase offsets. Two select inputs decide which tuning word drives the phase accumulator and which offset is applied before the lookup. On every clock the accumulator adds the active tuning word modulo 2^28. The twelve most significant accumulator bits plus the active 12-bit offset (modulo 4096) address a quarter-wave sine table, and the result is registered as a 10-bit offset-binary sample. The output frequency is tuning_word × f_clk / 2^28, with f_clk up to 50 MHz.

Software or a sequencer loads the four words through a one-cycle write strobe. A sweep controller can preload the next tuning word or offset into the register that is not in use. It then flips a select input, which changes the phase step or the phase on the following clock without a glitch in the accumulator. The asynchronous reset clears the accumulator and all four words and parks the output at midscale.

Top module: `dual_dds_sine`

## Requirements
- R1: While rst_ni is low, phase_o is 0 and sample_o is 512 (midscale); the tuning and offset words are cleared.
- R2: On each rising clock edge out of reset, phase_o becomes (phase_o + T) mod 2^28, where T is tuning word 1 when fsel_i is 1 and tuning word 0 otherwise, taken as they stood before the edge.
- R3: A change of fsel_i or psel_i is used at the very next clock edge and never resets or skips the accumulator.
- R4: One edge after phase_o holds P, sample_o equals the table value at address A = (P[27:16] + O) mod 4096, where O is offset 1 when psel_i is 1 and offset 0 otherwise. For A in 0..2047 the value is 512 + round(511·sin(2π(A+0.5)/4096)), and for A in 2048..4095 it is 511 + round(511·sin(2π(A+0.5)/4096)). Each value is within 2 LSB of this.
- R5: An offset write stores only wr_data_i[11:0]; the upper data bits are ignored.
- R6: A write with wr_en_i high updates a word at the clock edge: slot 0 is tuning word 0, slot 1 is tuning word 1, slot 2 is offset 0, slot 3 is offset 1. The accumulator step and lookup at that same edge still use the old value.
- R7: A write to the tuning word or offset that is not selected leaves phase_o and sample_o exactly as they would be without that write.
- R8: With tuning word 2^24 and a fixed offset, the sample sequence repeats every 16 clocks.
- R9: The accumulator wraps modulo 2^28: with tuning word 2^28 − 1 the phase counts down by one and goes from 0 to 0xFFFFFFF.
- R10: Samples at addresses A and A + 2048 (mod 4096) sum to exactly 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the word bank |
| wr_slot_i | input | 2 | Target word: 0/1 tuning, 2/3 offset |
| wr_data_i | input | 28 | Write data; offsets take bits 11:0 |
| fsel_i | input | 1 | Selects tuning word 1 when high |
| psel_i | input | 1 | Selects offset 1 when high |
| phase_o | output | 28 | Phase accumulator value |
| sample_o | output | 10 | Offset-binary sine sample |

## Verification
Tuning words from $urandom with a fixed seed, random writes to every slot and random flips of both selects exercise the accumulator step against a bench model. They also exercise the table lookup against a floating-point sine, which separates a wrong word, a wrong select or a wrong pipeline stage from a correct one. Several directed patterns cover corner cases. Writes to the idle registers show that idle slots are really isolated. A step of 2^28 − 1 exposes a missing modulo wrap. A step of 2^24 exposes an error in the 16-sample period or in the half-wave symmetry that would point to faulty mirroring. Offset writes with the high data bits set show that those bits are discarded.

// File: rtl/dds_pkg.sv
package dds_pkg;
    parameter int unsigned ACC_W    = 28;
    parameter int unsigned PHASE_W  = 12;
    parameter int unsigned SAMPLE_W = 10;

    typedef enum logic [1:0] {
        SLOT_TUNE0 = 2'd0,
        SLOT_TUNE1 = 2'd1,
        SLOT_OFF0  = 2'd2,
        SLOT_OFF1  = 2'd3
    } slot_e;
endpackage

// File: rtl/dds_word_bank.sv
module dds_word_bank #(
    parameter int unsigned ACC_W   = dds_pkg::ACC_W,
    parameter int unsigned PHASE_W = dds_pkg::PHASE_W
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_en_i,
    input  logic [1:0]                   wr_slot_i,
    input  logic [ACC_W-1:0]             wr_data_i,
    input  logic                         fsel_i,
    input  logic                         psel_i,
    output logic [1:0][ACC_W-1:0]        tune_o,
    output logic [1:0][PHASE_W-1:0]      off_o,
    output logic [ACC_W-1:0]             step_o,
    output logic [PHASE_W-1:0]           shift_o
);
    typedef struct packed {
        logic [1:0][ACC_W-1:0]   tune;
        logic [1:0][PHASE_W-1:0] off;
    } bank_t;

    bank_t state_d, state_q;
    logic [1:0] tune_hit, off_hit;

    // slot bit 1 chooses word kind, bit 0 chooses the copy
    for (genvar g = 0; g < 2; g++) begin : g_decode
        assign tune_hit[g] = wr_en_i && (wr_slot_i[1] == 1'b0) && (wr_slot_i[0] == g[0]);
        assign off_hit[g]  = wr_en_i && (wr_slot_i[1] == 1'b1) && (wr_slot_i[0] == g[0]);
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < 2; i++) begin
            if (tune_hit[i]) state_d.tune[i] = wr_data_i;
            if (off_hit[i])  state_d.off[i]  = wr_data_i[PHASE_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign tune_o  = state_q.tune;
    assign off_o   = state_q.off;
    assign step_o  = state_q.tune[fsel_i];
    assign shift_o = state_q.off[psel_i];
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int unsigned ACC_W = dds_pkg::ACC_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [ACC_W-1:0] step_i,
    output logic [ACC_W-1:0] phase_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d     = acc_q;
        acc_d.acc = acc_q.acc + step_i;   // natural wrap at 2^ACC_W
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) acc_q <= '0;
        else         acc_q <= acc_d;
    end

    assign phase_o = acc_q.acc;
endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
    parameter int unsigned PHASE_W  = dds_pkg::PHASE_W,
    parameter int unsigned SAMPLE_W = dds_pkg::SAMPLE_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [PHASE_W-1:0]  addr_i,
    output logic [SAMPLE_W-1:0] sample_o
);
    localparam int unsigned QIDX_W  = PHASE_W - 2;
    localparam int unsigned QSIZE   = 1 << QIDX_W;
    localparam int unsigned MAG_W   = SAMPLE_W - 1;
    localparam int unsigned MAG_MAX = (1 << MAG_W) - 1;
    localparam int unsigned MID     = 1 << (SAMPLE_W - 1);

    // Taylor coefficients of sin(pi/2 * x), scaled by 2^30
    localparam longint C1 = 64'sd1686629713;
    localparam longint C3 = 64'sd693598668;
    localparam longint C5 = 64'sd85569306;
    localparam longint C7 = 64'sd5026996;

    function automatic logic [MAG_W-1:0] quarter_val(input int unsigned idx);
        longint x, x2, y, r;
        x  = (longint'(2 * idx + 1) <<< 30) / longint'(2 * QSIZE);
        x2 = (x * x) >>> 30;
        y  = C7;
        y  = C5 - ((x2 * y) >>> 30);
        y  = C3 - ((x2 * y) >>> 30);
        y  = C1 - ((x2 * y) >>> 30);
        y  = (x * y) >>> 30;
        r  = (longint'(MAG_MAX) * y + (longint'(1) <<< 29)) >>> 30;
        if (r > longint'(MAG_MAX)) r = longint'(MAG_MAX);
        if (r < 0) r = 0;
        return MAG_W'(r);
    endfunction

    logic [MAG_W-1:0] rom [QSIZE];

    for (genvar g = 0; g < QSIZE; g++) begin : g_rom
        assign rom[g] = quarter_val(g);
    end

    typedef struct packed {
        logic [SAMPLE_W-1:0] sample;
    } lut_t;

    lut_t lut_d, lut_q;
    logic              neg_half, mirror;
    logic [QIDX_W-1:0] qidx;
    logic [MAG_W-1:0]  mag;

    always_comb begin
        neg_half = addr_i[PHASE_W-1];
        mirror   = addr_i[PHASE_W-2];
        qidx     = mirror ? ~addr_i[QIDX_W-1:0] : addr_i[QIDX_W-1:0];
        mag      = rom[qidx];
        lut_d    = lut_q;
        if (neg_half) lut_d.sample = SAMPLE_W'(MID - 1) - SAMPLE_W'(mag);
        else          lut_d.sample = SAMPLE_W'(MID) + SAMPLE_W'(mag);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lut_q.sample <= SAMPLE_W'(MID);
        else         lut_q <= lut_d;
    end

    assign sample_o = lut_q.sample;
endmodule

// File: rtl/dual_dds_sine.sv
module dual_dds_sine #(
    parameter int unsigned ACC_W    = dds_pkg::ACC_W,
    parameter int unsigned PHASE_W  = dds_pkg::PHASE_W,
    parameter int unsigned SAMPLE_W = dds_pkg::SAMPLE_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_slot_i,
    input  logic [ACC_W-1:0]    wr_data_i,
    input  logic                fsel_i,
    input  logic                psel_i,
    output logic [ACC_W-1:0]    phase_o,
    output logic [SAMPLE_W-1:0] sample_o
);
    logic [1:0][ACC_W-1:0]   tune_w;
    logic [1:0][PHASE_W-1:0] off_w;
    logic [ACC_W-1:0]        step_w;
    logic [PHASE_W-1:0]      shift_w;
    logic [PHASE_W-1:0]      addr_w;

    dds_word_bank #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_slot_i(wr_slot_i),
        .wr_data_i(wr_data_i),
        .fsel_i   (fsel_i),
        .psel_i   (psel_i),
        .tune_o   (tune_w),
        .off_o    (off_w),
        .step_o   (step_w),
        .shift_o  (shift_w)
    );

    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (step_w),
        .phase_o(phase_o)
    );

    // offset added to the coarse phase, wrapping modulo 2^PHASE_W
    assign addr_w = phase_o[ACC_W-1 -: PHASE_W] + shift_w;

    dds_sine_lut #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_lut (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (addr_w),
        .sample_o(sample_o)
    );
endmodule

// File: rtl/dds_checker.sv
module dds_checker #(
    parameter int unsigned ACC_W    = dds_pkg::ACC_W,
    parameter int unsigned PHASE_W  = dds_pkg::PHASE_W,
    parameter int unsigned SAMPLE_W = dds_pkg::SAMPLE_W
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    wr_en_i,
    input logic [1:0]              wr_slot_i,
    input logic [ACC_W-1:0]        wr_data_i,
    input logic [1:0][ACC_W-1:0]   tune_w,
    input logic [1:0][PHASE_W-1:0] off_w,
    input logic [ACC_W-1:0]        step_w,
    input logic [ACC_W-1:0]        phase_o,
    input logic [SAMPLE_W-1:0]     sample_o
);
    localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1 << (SAMPLE_W - 1));
    localparam logic [ACC_W:0]      TOP = {1'b0, {ACC_W{1'b1}}};

    p_reset_mid_r1: assert property (@(posedge clk_i)
        !rst_ni |-> (phase_o == '0 && sample_o == MID));

    p_acc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> phase_o == ACC_W'($past(phase_o) + $past(step_w)));

    p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && (({1'b0, $past(phase_o)} + {1'b0, $past(step_w)}) > TOP))
        |-> phase_o < $past(phase_o));

    p_tune_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_slot_i[1]) |=> tune_w[$past(wr_slot_i[0])] == $past(wr_data_i));

    p_off_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_slot_i[1]) |=> off_w[$past(wr_slot_i[0])] == $past(wr_data_i[PHASE_W-1:0]));
endmodule

bind dual_dds_sine dds_checker #(
    .ACC_W(ACC_W), .PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_slot_i(wr_slot_i),
    .wr_data_i(wr_data_i),
    .tune_w   (tune_w),
    .off_w    (off_w),
    .step_w   (step_w),
    .phase_o  (phase_o),
    .sample_o (sample_o)
);

// File: tb/test_dual_dds_sine.sv
module test_dual_dds_sine;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_slot_i = 2'd0;
    logic [27:0] wr_data_i = '0;
    logic        fsel_i = 1'b0;
    logic        psel_i = 1'b0;
    logic [27:0] phase_o;
    logic [9:0]  sample_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [27:0] m_tune [2];
    logic [11:0] m_off  [2];
    logic [27:0] m_phase;
    logic [11:0] m_addr;
    logic [9:0]  cap [48];

    always #5 clk_i = ~clk_i;

    dual_dds_sine i_dual_dds_sine (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_slot_i(wr_slot_i),
        .wr_data_i(wr_data_i), .fsel_i(fsel_i), .psel_i(psel_i),
        .phase_o(phase_o), .sample_o(sample_o)
    );

    function automatic real ideal(input logic [11:0] a);
        real s;
        s = $sin(2.0 * 3.14159265358979 * (real'(a) + 0.5) / 4096.0);
        return (a[11] == 1'b0) ? 512.0 + 511.0 * s : 511.0 + 511.0 * s;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_phase(input string req);
        chk(phase_o == m_phase, req, phase_o, m_phase);
    endtask

    task automatic check_sample(input string req);
        real e, d;
        e = ideal(m_addr);
        d = real'(sample_o) - e;
        chk(d <= 2.0 && d >= -2.0, req, sample_o, longint'($rtoi(e + 0.5)));
    endtask

    // one clock edge; model follows the pre-edge register and input values
    task automatic tick();
        logic [27:0] nphase;
        logic [11:0] naddr;
        naddr  = m_phase[27:16] + m_off[psel_i];
        nphase = m_phase + m_tune[fsel_i];
        if (wr_en_i) begin
            if (!wr_slot_i[1]) m_tune[wr_slot_i[0]] = wr_data_i;
            else               m_off[wr_slot_i[0]]  = wr_data_i[11:0];
        end
        @(posedge clk_i);
        #1;
        m_phase = nphase;
        m_addr  = naddr;
    endtask

    task automatic write(input logic [1:0] slot, input logic [27:0] data);
        wr_en_i = 1'b1; wr_slot_i = slot; wr_data_i = data;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic do_reset();
        wr_en_i = 1'b0; fsel_i = 1'b0; psel_i = 1'b0;
        rst_ni = 1'b0;
        @(posedge clk_i);
        #1;
        chk(phase_o == '0, "R1 phase", phase_o, 0);
        chk(sample_o == 10'd512, "R1 sample", sample_o, 512);
        rst_ni = 1'b1;
        m_tune[0] = '0; m_tune[1] = '0; m_off[0] = '0; m_off[1] = '0;
        m_phase = '0; m_addr = '0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [27:0] p0;
        void'($urandom(32'h5eed_0042));
        #2;
        do_reset();

        // R6, R2, R4: load tuning word 0 and run
        write(2'd0, 28'h0123457);
        check_phase("R6 write edge uses old step");
        for (int i = 0; i < 20; i++) begin
            tick();
            check_phase("R2 step tune0");
            check_sample("R4 lookup");
        end

        // R3: switch to tuning word 1, no accumulator reset
        write(2'd1, 28'h0400000);
        fsel_i = 1'b1;
        p0 = m_phase;
        tick();
        check_phase("R3 select takes effect next edge");
        chk(phase_o == p0 + 28'h0400000, "R3 no reset", phase_o, p0 + 28'h0400000);

        // R5: offset write with junk upper bits
        write(2'd3, 28'hFFFF800);
        psel_i = 1'b1;
        tick();
        tick();
        check_sample("R5 offset low bits only");
        chk(m_off[1] == 12'h800, "R5 model", m_off[1], 12'h800);

        // R7: writes to idle registers
        fsel_i = 1'b0; psel_i = 1'b0;
        tick();
        for (int i = 0; i < 6; i++) begin
            p0 = m_phase + m_tune[0];
            write(i[0] ? 2'd3 : 2'd1, 28'($urandom));
            chk(phase_o == p0, "R7 idle write phase", phase_o, p0);
            check_sample("R7 idle write sample");
        end

        // R9: wrap downward
        do_reset();
        write(2'd0, 28'hFFFFFFF);
        tick();
        chk(phase_o == 28'hFFFFFFF, "R9 wrap", phase_o, 28'hFFFFFFF);
        tick();
        check_phase("R9 count down");

        // R8, R10: step 2^24
        do_reset();
        write(2'd0, 28'h1000000);
        for (int i = 0; i < 48; i++) begin
            tick();
            cap[i] = sample_o;
            check_sample("R4 step 2^24");
        end
        for (int i = 0; i < 32; i++)
            chk(cap[i] == cap[i+16], "R8 period 16", cap[i+16], cap[i]);
        for (int i = 0; i < 40; i++)
            chk(11'(cap[i]) + 11'(cap[i+8]) == 11'd1023, "R10 half-wave sum",
                11'(cap[i]) + 11'(cap[i+8]), 1023);

        // random mix: R2, R3, R4, R6
        for (int i = 0; i < 3000; i++) begin
            wr_en_i   = ($urandom % 4) == 0;
            wr_slot_i = 2'($urandom);
            wr_data_i = 28'($urandom);
            if (($urandom % 8) == 0) fsel_i = ~fsel_i;
            if (($urandom % 8) == 0) psel_i = ~psel_i;
            tick();
            check_phase("R2 random");
            check_sample("R4 random");
        end
        wr_en_i = 1'b0;

        do_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule